// File: doc/BRIEF.md
# Multi-Polynomial PRBS Pattern Generator

This block makes the parallel test pattern that feeds a transceiver lane's serializer during link bring-up and bit-error testing. Each enabled clock cycle it emits one `W`-bit word. The word comes either from a linear feedback shift register that runs one of four standard pseudo-random polynomials (degree 7, 9, 23 or 31) or from a square wave with runs of `N` ones and `N` zeros. The serial order of the word is most significant bit first.

Software, or a lane controller, drives the pattern through a small set of level inputs. Two enables must both be high for the block to run: a clock enable for the generator and a test enable for the lane. A pattern-type bit chooses between the square wave and the pseudo-random source. A one-hot select chooses the polynomial. The block can be switched between polynomials and modes at run time. On a change of polynomial it starts that polynomial again from a fixed all-ones seed, so the shift register can never be stuck in the all-zero state.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While reset is held, and in the cycles after it until the first enabled step, `data_valid` is 0 and `data_out` is all zeros.
- R2: A cycle is enabled when `clk_en` and `test_en` are both 1 and either `pat_square` is 1 or `poly_sel` is nonzero. Each enabled cycle produces a word on `data_out` with `data_valid`=1 in the next cycle. After any other cycle `data_valid` is 0 and `data_out` is all zeros.
- R3: In pseudo-random mode each output bit is the feedback bit of one shift step, and the W steps of a cycle fill the word from bit W-1 down to bit 0. For a polynomial x^n + x^k + 1, one step computes fb = s[n-1] xor s[k-1] and then s becomes {s[n-2:0], fb}. The first PRBS-7 word after reset with W=10 is 10'h008.
- R4: `poly_sel` bit 0 selects PRBS-7, x^7 + x^6 + 1.
- R5: `poly_sel` bit 1 selects PRBS-9, x^9 + x^5 + 1.
- R6: `poly_sel` bit 2 selects PRBS-23, x^23 + x^18 + 1.
- R7: `poly_sel` bit 3 selects PRBS-31, x^31 + x^28 + 1.
- R8: When several `poly_sel` bits are set, the highest set bit wins. The priority order is PRBS-31, then PRBS-23, then PRBS-9, then PRBS-7.
- R9: The shift register starts from all ones after reset. It also starts from all ones at the first pseudo-random step that uses a different polynomial from the previous pseudo-random step.
- R10: With `pat_square`=1 the output is a square wave. The stream starts right after reset with N ones, then N zeros, and so on. In the stream, bit p is 1 when (p mod 2N) < N, and p counts only the square-mode bits. With N=3 and W=10, the first two square words are 10'h38E and 10'h0E3.
- R11: `pat_square`=1 has priority over `poly_sel`. Disabled cycles and square-mode cycles leave the shift register unchanged, so the pseudo-random sequence continues where it stopped when that mode returns. Pseudo-random and disabled cycles likewise leave the square-wave phase unchanged.
- R12: The shift register never holds the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| clk_en | input | 1 | Generator clock enable |
| test_en | input | 1 | Lane test enable |
| pat_square | input | 1 | 1 selects the square wave, 0 selects the pseudo-random pattern |
| poly_sel | input | 4 | One-hot polynomial select: bit0 PRBS-7, bit1 PRBS-9, bit2 PRBS-23, bit3 PRBS-31 |
| data_out | output | W | Pattern word, bit W-1 first in time |
| data_valid | output | 1 | High for the cycle after an enabled cycle |

## Verification
The bench builds the generator with W=10 and N=3, where the defaults are W=16 and N=4. A word width that is not a multiple of the square-wave period 2N makes the phase land on a different offset in each word. With the defaults every square word would be the same value, so a phase-tracking fault would stay hidden. The ten-bit word also splits each polynomial's feedback history across word boundaries, which exposes ordering and unrolling errors. It keeps the hand-worked expected words for PRBS-7 and for the square wave short enough to check by hand.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  localparam int unsigned LFSR_LEN = 31;

  typedef enum logic [1:0] {
    POLY_P7  = 2'd0,
    POLY_P9  = 2'd1,
    POLY_P23 = 2'd2,
    POLY_P31 = 2'd3
  } poly_e;

endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end

endmodule

// File: rtl/prbs_poly_pick.sv
module prbs_poly_pick
  import prbs_gen_pkg::*;
(
  input  logic [3:0] sel,
  output poly_e      poly,
  output logic       any
);

  // Highest set bit wins: 31 > 23 > 9 > 7 (R8)
  always_comb begin
    any = |sel;
    if (sel[3])      poly = POLY_P31;
    else if (sel[2]) poly = POLY_P23;
    else if (sel[1]) poly = POLY_P9;
    else             poly = POLY_P7;
  end

endmodule

// File: rtl/prbs_lfsr_unroll.sv
module prbs_lfsr_unroll
  import prbs_gen_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  poly_e                 poly,
  input  logic [LFSR_LEN-1:0]   state_in,
  output logic [LFSR_LEN-1:0]   state_out,
  output logic [W-1:0]          word
);

  logic [LFSR_LEN-1:0] s;
  logic                fb;

  // W Fibonacci steps per cycle; first step lands in the MSB (R3)
  always_comb begin
    s    = state_in;
    fb   = 1'b0;
    word = '0;
    for (int i = 0; i < int'(W); i++) begin
      case (poly)
        POLY_P7:  fb = s[6]  ^ s[5];
        POLY_P9:  fb = s[8]  ^ s[4];
        POLY_P23: fb = s[22] ^ s[17];
        default:  fb = s[30] ^ s[27];
      endcase
      s = {s[LFSR_LEN-2:0], fb};
      word[int'(W) - 1 - i] = fb;
    end
    state_out = s;
  end

endmodule

// File: rtl/prbs_square_gen.sv
module prbs_square_gen #(
  parameter int unsigned W  = 16,
  parameter int unsigned N  = 4,
  localparam int unsigned PERIOD = 2 * N,
  localparam int unsigned PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic [PW-1:0] phase,
  output logic [PW-1:0] phase_nxt,
  output logic [W-1:0]  word
);

  int unsigned pos;

  always_comb begin
    pos  = 0;
    word = '0;
    for (int unsigned i = 0; i < W; i++) begin
      pos = (32'(phase) + i) % PERIOD;
      word[W - 1 - i] = (pos < N);
    end
    phase_nxt = PW'((32'(phase) + W) % PERIOD);
  end

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_gen_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         test_en,
  input  logic         pat_square,
  input  logic [3:0]   poly_sel,
  output logic [W-1:0] data_out,
  output logic         data_valid
);

  localparam int unsigned PERIOD = 2 * N;
  localparam int unsigned PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic                rst_n_sync;
  poly_e               poly_eff;
  logic                poly_any;
  logic                run;
  logic                step_prbs;
  logic                step_sq;

  logic [LFSR_LEN-1:0] lfsr_q, lfsr_d, lfsr_src, lfsr_nxt;
  poly_e               poly_q, poly_d;
  logic [PW-1:0]       phase_q, phase_d, phase_nxt;
  logic [W-1:0]        prbs_word, sq_word;
  logic [W-1:0]        data_d;
  logic                valid_d;

  prbs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  prbs_poly_pick u_poly_pick (
    .sel  (poly_sel),
    .poly (poly_eff),
    .any  (poly_any)
  );

  prbs_lfsr_unroll #(.W(W)) u_lfsr (
    .poly      (poly_eff),
    .state_in  (lfsr_src),
    .state_out (lfsr_nxt),
    .word      (prbs_word)
  );

  prbs_square_gen #(.W(W), .N(N)) u_square (
    .phase     (phase_q),
    .phase_nxt (phase_nxt),
    .word      (sq_word)
  );

  // Next-state logic
  always_comb begin
    run       = clk_en & test_en & (pat_square | poly_any);
    step_prbs = run & ~pat_square;
    step_sq   = run & pat_square;
    // Restart from all ones when the polynomial differs from the last one stepped (R9)
    lfsr_src  = (poly_eff != poly_q) ? {LFSR_LEN{1'b1}} : lfsr_q;
    lfsr_d    = step_prbs ? lfsr_nxt : lfsr_q;
    poly_d    = step_prbs ? poly_eff : poly_q;
    phase_d   = step_sq   ? phase_nxt : phase_q;
    if (step_prbs)    data_d = prbs_word;
    else if (step_sq) data_d = sq_word;
    else              data_d = '0;
    valid_d   = run;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      lfsr_q     <= {LFSR_LEN{1'b1}};
      poly_q     <= POLY_P31;
      phase_q    <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
    end else begin
      lfsr_q     <= lfsr_d;
      poly_q     <= poly_d;
      phase_q    <= phase_d;
      data_out   <= data_d;
      data_valid <= valid_d;
    end
  end

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         clk_en,
  input logic         test_en,
  input logic         pat_square,
  input logic [3:0]   poly_sel,
  input logic [W-1:0] data_out,
  input logic         data_valid,
  input logic [30:0]  lfsr_state
);

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_ok)
    !(clk_en && test_en) |=> !data_valid); // R2

  AST_RUN_VALID: assert property (@(posedge clk) disable iff (!rst_ok)
    (clk_en && test_en && (pat_square || (poly_sel != 4'b0))) |=> data_valid); // R2

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    !data_valid |-> (data_out == '0)); // R1

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_ok)
    lfsr_state != 31'd0); // R12

  AST_HOLD_WHEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_ok)
    (!(clk_en && test_en) || pat_square) |=> $stable(lfsr_state)); // R11

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_n_sync),
  .clk_en     (clk_en),
  .test_en    (test_en),
  .pat_square (pat_square),
  .poly_sel   (poly_sel),
  .data_out   (data_out),
  .data_valid (data_valid),
  .lfsr_state (lfsr_q)
);

// File: tb/prbs_pattern_gen_bench.sv
`timescale 1ns/1ps
module prbs_pattern_gen_bench;

  localparam int unsigned W = 10;
  localparam int unsigned N = 3;

  logic         clk;
  logic         rst_n;
  logic         clk_en;
  logic         test_en;
  logic         pat_square;
  logic [3:0]   poly_sel;
  logic [W-1:0] data_out;
  logic         data_valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // reference model state
  logic [30:0] m_lfsr;
  int          m_poly;   // 0:P7 1:P9 2:P23 3:P31
  int          m_phase;

  prbs_pattern_gen #(.W(W), .N(N)) u_prbs_pattern_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .test_en    (test_en),
    .pat_square (pat_square),
    .poly_sel   (poly_sel),
    .data_out   (data_out),
    .data_valid (data_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int eff_poly(logic [3:0] sel);
    if (sel[3]) return 3;
    if (sel[2]) return 2;
    if (sel[1]) return 1;
    return 0;
  endfunction

  task automatic model_prbs(logic [3:0] sel, output logic [W-1:0] w);
    int p, n, k;
    logic fb;
    p = eff_poly(sel);
    if (p != m_poly) m_lfsr = '1;
    m_poly = p;
    case (p)
      0: begin n = 7;  k = 6;  end
      1: begin n = 9;  k = 5;  end
      2: begin n = 23; k = 18; end
      default: begin n = 31; k = 28; end
    endcase
    w = '0;
    for (int i = 0; i < int'(W); i++) begin
      fb = m_lfsr[n-1] ^ m_lfsr[k-1];
      m_lfsr = {m_lfsr[29:0], fb};
      w[int'(W) - 1 - i] = fb;
    end
  endtask

  task automatic model_sq(output logic [W-1:0] w);
    w = '0;
    for (int i = 0; i < int'(W); i++)
      w[int'(W) - 1 - i] = (((m_phase + i) % (2 * int'(N))) < int'(N));
    m_phase = (m_phase + int'(W)) % (2 * int'(N));
  endtask

  // Drive one cycle at a negedge, check the registered result one cycle later.
  task automatic apply(bit ce, bit te, bit sq, logic [3:0] sel, string tag,
                       output logic [W-1:0] got);
    logic [W-1:0] exp;
    bit ev;
    clk_en = ce; test_en = te; pat_square = sq; poly_sel = sel;
    ev  = ce && te && (sq || sel != 4'b0);
    exp = '0;
    if (ev && sq)  model_sq(exp);
    else if (ev)   model_prbs(sel, exp);
    @(negedge clk);
    got = data_out;
    chk(data_valid == ev, tag, "valid", 32'(data_valid), 32'(ev));
    chk(data_out == exp, tag, "data", 32'(data_out), 32'(exp));
  endtask

  task automatic do_reset();
    clk_en = 0; test_en = 0; pat_square = 0; poly_sel = 4'b0;
    rst_n = 0;
    m_lfsr = '1; m_poly = 3; m_phase = 0;
    repeat (2) @(negedge clk);
    chk(data_valid == 1'b0, "R1", "valid in reset", 32'(data_valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(data_valid == 1'b0, "R1", "valid after reset", 32'(data_valid), 0);
    chk(data_out == '0, "R1", "data after reset", 32'(data_out), 0);
  endtask

  task automatic t_gating();
    logic [W-1:0] g;
    apply(0, 1, 0, 4'b0001, "R2", g);
    apply(1, 0, 0, 4'b0001, "R2", g);
    apply(1, 1, 0, 4'b0000, "R2", g);
    apply(0, 0, 1, 4'b0000, "R2", g);
  endtask

  task automatic t_prbs7_first();
    logic [W-1:0] g;
    do_reset();
    apply(1, 1, 0, 4'b0001, "R3", g);
    chk(g == 10'h008, "R3", "first prbs7 word", 32'(g), 32'h008);
    for (int i = 0; i < 20; i++) apply(1, 1, 0, 4'b0001, "R4", g);
  endtask

  task automatic t_poly(logic [3:0] sel, string tag);
    logic [W-1:0] g;
    for (int i = 0; i < 12; i++) apply(1, 1, 0, sel, tag, g);
  endtask

  task automatic t_priority();
    logic [W-1:0] g;
    for (int i = 0; i < 4; i++) apply(1, 1, 0, 4'b1111, "R8", g);
    for (int i = 0; i < 4; i++) apply(1, 1, 0, 4'b0110, "R8", g);
    for (int i = 0; i < 4; i++) apply(1, 1, 0, 4'b0011, "R8", g);
  endtask

  task automatic t_reseed();
    logic [W-1:0] g;
    logic [W-1:0] first;
    do_reset();
    apply(1, 1, 0, 4'b0001, "R9", first);
    for (int i = 0; i < 5; i++) apply(1, 1, 0, 4'b0001, "R9", g);
    apply(1, 1, 0, 4'b0010, "R9", g);
    apply(1, 1, 0, 4'b0001, "R9", g);
    chk(g == first, "R9", "prbs7 restarts from seed", 32'(g), 32'(first));
  endtask

  task automatic t_square();
    logic [W-1:0] g;
    do_reset();
    apply(1, 1, 1, 4'b0000, "R10", g);
    chk(g == 10'h38E, "R10", "first square word", 32'(g), 32'h38E);
    apply(1, 1, 1, 4'b1000, "R10", g);
    chk(g == 10'h0E3, "R10", "second square word", 32'(g), 32'h0E3);
    for (int i = 0; i < 6; i++) apply(1, 1, 1, 4'b0000, "R10", g);
  endtask

  task automatic t_pause_resume();
    logic [W-1:0] g;
    for (int i = 0; i < 3; i++) apply(1, 1, 0, 4'b0100, "R11", g);
    apply(0, 1, 0, 4'b0100, "R11", g);
    apply(1, 0, 0, 4'b0100, "R11", g);
    for (int i = 0; i < 3; i++) apply(1, 1, 1, 4'b0100, "R11", g);
    for (int i = 0; i < 3; i++) apply(1, 1, 0, 4'b0100, "R11", g);
    apply(1, 1, 1, 4'b0000, "R11", g);
  endtask

  initial begin
    rst_n = 0; clk_en = 0; test_en = 0; pat_square = 0; poly_sel = 4'b0;
    @(negedge clk);
    do_reset();
    t_gating();
    t_prbs7_first();
    t_poly(4'b0010, "R5");
    t_poly(4'b0100, "R6");
    t_poly(4'b1000, "R7");
    t_poly(4'b0001, "R4");
    t_priority();
    t_reseed();
    t_square();
    t_pause_resume();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule